// File: doc/BRIEF.md
# Shadowed Nonvolatile Block Manager

This block holds three small user storage blocks. Each block lives in a shadow RAM that the host reads and writes, and behind it sits a modelled nonvolatile array. Host writes only change the shadow copy. A command byte then moves one whole block in one of three ways: it copies the shadow into the nonvolatile array, it recalls the nonvolatile contents into the shadow, or it locks the block for good. A copy or a lock takes a programmable number of clock cycles and raises a busy flag for that time. The time stands in for the programming time of a real cell array.

The host talks to the block over a simple register bus. An address, a write data byte and a write strobe write registers and shadow bytes. The read data comes back one cycle after the address. A command strobe makes the block take the write data byte as a command code. A status byte shows the busy flag, a lock-arm bit and a read-only lock flag for each block.

At reset, which stands for power-up, every shadow byte is reloaded from the nonvolatile array. The three configuration outputs are loaded from the first two bytes of block 1. A later recall of block 1 refreshes the same outputs.

Top module: `nvblk_mgr`

## Requirements
- R1: A write strobe to an address from 0x20 to 0x47 stores the byte in shadow RAM, if the block is unlocked and is not the target of a running operation. Block 0 is 0x20–0x2F, block 1 is 0x30–0x3F and block 2 is 0x40–0x47. A read returns the stored byte on rdata one cycle after the address is presented.
- R2: Copy codes 0x42, 0x44 and 0x48 target blocks 0, 1 and 2. An accepted copy raises busy on the following cycle, holds it for exactly PROG_CYC cycles, and then writes the whole shadow block into the nonvolatile array. While busy is high, status bit 7 reads 1.
- R3: Recall codes 0xB2, 0xB4 and 0xB8 load blocks 0, 1 and 2 from the nonvolatile array into shadow RAM in a single cycle. A recall works on locked blocks as well as unlocked ones.
- R4: While busy is high, writes inside the target block are ignored. Writes to other blocks and to the status byte still take effect.
- R5: A command strobe while busy is dropped with no effect. An unknown code is also dropped with no effect.
- R6: Lock codes 0x63, 0x66 and 0x6A target blocks 0, 1 and 2. A lock is accepted only when the arm bit (bit 6 of 0x07) is 1. It then runs busy for PROG_CYC cycles, sets the lock flag of the block, and clears the arm bit. With the arm bit at 0, a lock code is dropped.
- R7: A locked block ignores host writes. A copy that targets a locked block is dropped and does not raise busy.
- R8: Lock flags sit at bits 2, 1 and 0 of 0x07 for blocks 2, 1 and 0. They never clear, whether by a write or by reset. A write to 0x07 changes only the arm bit.
- R9: On reset, busy and the arm bit clear, and every shadow byte is reloaded from the nonvolatile array. The outputs are loaded from nonvolatile 0x30 bit 1 (chg_en) and bit 0 (dis_en), and from 0x31 bit 5 (sleep_en).
- R10: A recall of block 1 also reloads chg_en, dis_en and sleep_en from the same bits. The new values are visible on the cycle after the command strobe.
- R11: Status bits 5 to 3 read 0. A read of any address other than 0x07 or 0x20–0x47 returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset (power-up) |
| addr | input | 8 | Register address for read and write |
| wdata | input | 8 | Write data, or command code when cmd_en is high |
| wr_en | input | 1 | Write strobe |
| cmd_en | input | 1 | Command strobe; wdata holds the code |
| rdata | output | 8 | Registered read data for addr |
| busy | output | 1 | Copy or lock in progress |
| chg_en | output | 1 | Default charge enable from block 1 |
| dis_en | output | 1 | Default discharge enable from block 1 |
| sleep_en | output | 1 | Default sleep enable from block 1 |

## Verification
The assertions assume that the host never raises wr_en and cmd_en in the same cycle. They also assume that a command code stays valid only for the cycle of its strobe. If both strobes did arrive together, the command would win and the write would be lost, which the properties do not cover. The stimulus drives each strobe for exactly one clock at a falling edge and never overlaps them. It places writes and a second command inside a busy window, so that target-block gating and refusal while busy are exercised at the edges the properties watch.

// File: rtl/nvblk_pkg.sv
package nvblk_pkg;
  localparam int unsigned NUM_BLK   = 3;
  localparam int unsigned MEM_BYTES = 40;
  localparam int unsigned IDX_W     = $clog2(MEM_BYTES);
  localparam logic [7:0]  MEM_BASE  = 8'h20;
  localparam logic [7:0]  MEM_END   = MEM_BASE + 8'(MEM_BYTES);
  localparam logic [7:0]  STAT_ADDR = 8'h07;
  localparam int unsigned CFG0_IDX  = 16;
  localparam int unsigned CFG1_IDX  = 17;

  typedef enum logic [1:0] {OP_NONE, OP_COPY, OP_RECALL, OP_LOCK} op_e;

  typedef struct packed {
    op_e        op;
    logic [1:0] blk;
  } cmd_t;

  function automatic logic [1:0] blk_of(input logic [IDX_W-1:0] idx);
    if (idx < IDX_W'(16))      return 2'd0;
    else if (idx < IDX_W'(32)) return 2'd1;
    else                       return 2'd2;
  endfunction

  function automatic logic in_mem(input logic [7:0] a);
    return (a >= MEM_BASE) && (a < MEM_END);
  endfunction
endpackage

// File: rtl/nvblk_cmd_dec.sv
module nvblk_cmd_dec
  import nvblk_pkg::*;
(
  input  logic [7:0] code,
  output cmd_t       cmd
);
  always_comb begin
    cmd = '{op: OP_NONE, blk: 2'd0};
    case (code)
      8'h42: cmd = '{op: OP_COPY,   blk: 2'd0};
      8'h44: cmd = '{op: OP_COPY,   blk: 2'd1};
      8'h48: cmd = '{op: OP_COPY,   blk: 2'd2};
      8'hB2: cmd = '{op: OP_RECALL, blk: 2'd0};
      8'hB4: cmd = '{op: OP_RECALL, blk: 2'd1};
      8'hB8: cmd = '{op: OP_RECALL, blk: 2'd2};
      8'h63: cmd = '{op: OP_LOCK,   blk: 2'd0};
      8'h66: cmd = '{op: OP_LOCK,   blk: 2'd1};
      8'h6A: cmd = '{op: OP_LOCK,   blk: 2'd2};
      default: cmd = '{op: OP_NONE, blk: 2'd0};
    endcase
  end
endmodule

// File: rtl/nvblk_timer.sv
module nvblk_timer #(
  parameter int unsigned PROG_CYC = 100000
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic busy,
  output logic done
);
  localparam int unsigned CW = $clog2(PROG_CYC + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (start && !busy) begin
      busy <= 1'b1;
      cnt  <= CW'(PROG_CYC - 1);
    end else if (busy) begin
      if (cnt == '0) busy <= 1'b0;
      else           cnt  <= cnt - 1'b1;
    end
  end

  assign done = busy && (cnt == '0);

  p_busy_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (busy && cnt != '0) |=> busy);

  p_start_idle_r5: assert property (@(posedge clk) disable iff (rst)
    start |-> !busy);
endmodule

// File: rtl/nvblk_store.sv
module nvblk_store
  import nvblk_pkg::*;
#(
  parameter logic [7:0] NV_INIT = 8'hFF
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [7:0]       wr_data,
  input  logic             rcl_en,
  input  logic [1:0]       rcl_blk,
  input  logic             cpy_en,
  input  logic [1:0]       cpy_blk,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [7:0]       rd_data,
  output logic [7:0]       cfg0,
  output logic [7:0]       cfg1
);
  logic [7:0] shadow [MEM_BYTES];
  logic [7:0] nv     [MEM_BYTES] = '{default: NV_INIT};

  always_ff @(posedge clk) begin
    if (cpy_en) begin
      for (int i = 0; i < MEM_BYTES; i++)
        if (blk_of(IDX_W'(i)) == cpy_blk) nv[i] <= shadow[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < MEM_BYTES; i++) shadow[i] <= nv[i];
    end else begin
      if (wr_en) shadow[wr_idx] <= wr_data;
      if (rcl_en) begin
        for (int i = 0; i < MEM_BYTES; i++)
          if (blk_of(IDX_W'(i)) == rcl_blk) shadow[i] <= nv[i];
      end
    end
  end

  assign rd_data = shadow[rd_idx];
  assign cfg0    = nv[CFG0_IDX];
  assign cfg1    = nv[CFG1_IDX];
endmodule

// File: rtl/nvblk_mgr.sv
module nvblk_mgr
  import nvblk_pkg::*;
#(
  parameter int unsigned PROG_CYC = 100000,
  parameter logic [7:0]  NV_INIT  = 8'hFF
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [7:0] addr,
  input  logic [7:0] wdata,
  input  logic       wr_en,
  input  logic       cmd_en,
  output logic [7:0] rdata,
  output logic       busy,
  output logic       chg_en,
  output logic       dis_en,
  output logic       sleep_en
);
  cmd_t               dc;
  cmd_t               act_q;
  logic [NUM_BLK-1:0] lock_q = '0;
  logic               arm_q;
  logic               busy_w, done_w, start, rcl, wr_ok, mem_hit;
  logic [IDX_W-1:0]   idx;
  logic [1:0]         ablk;
  logic [7:0]         sh_rd, cfg0, cfg1;

  nvblk_cmd_dec u_dec (.code(wdata), .cmd(dc));

  assign mem_hit = in_mem(addr);
  assign idx     = IDX_W'(addr - MEM_BASE);
  assign ablk    = blk_of(idx);

  assign start = cmd_en && !busy_w && !lock_q[dc.blk] &&
                 ((dc.op == OP_COPY) || (dc.op == OP_LOCK && arm_q));
  assign rcl   = cmd_en && !busy_w && (dc.op == OP_RECALL);
  assign wr_ok = wr_en && !cmd_en && mem_hit && !lock_q[ablk] &&
                 !(busy_w && ablk == act_q.blk);

  nvblk_timer #(.PROG_CYC(PROG_CYC)) u_tmr (
    .clk(clk), .rst(rst), .start(start), .busy(busy_w), .done(done_w)
  );

  nvblk_store #(.NV_INIT(NV_INIT)) u_mem (
    .clk(clk), .rst(rst),
    .wr_en(wr_ok), .wr_idx(idx), .wr_data(wdata),
    .rcl_en(rcl), .rcl_blk(dc.blk),
    .cpy_en(done_w && act_q.op == OP_COPY), .cpy_blk(act_q.blk),
    .rd_idx(idx), .rd_data(sh_rd), .cfg0(cfg0), .cfg1(cfg1)
  );

  // lock flags model nonvolatile cells: no reset
  always_ff @(posedge clk) begin
    if (done_w && act_q.op == OP_LOCK) lock_q[act_q.blk] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      arm_q <= 1'b0;
      act_q <= '{op: OP_NONE, blk: 2'd0};
    end else begin
      if (start) act_q <= dc;
      if (wr_en && !cmd_en && addr == STAT_ADDR) arm_q <= wdata[6];
      if (done_w && act_q.op == OP_LOCK) arm_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || (rcl && dc.blk == 2'd1)) begin
      chg_en   <= cfg0[1];
      dis_en   <= cfg0[0];
      sleep_en <= cfg1[5];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                    rdata <= 8'h00;
    else if (addr == STAT_ADDR) rdata <= {busy_w, arm_q, 3'b000, lock_q};
    else if (mem_hit)           rdata <= sh_rd;
    else                        rdata <= 8'h00;
  end

  assign busy = busy_w;

  p_lock_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    ((lock_q & $past(lock_q)) == $past(lock_q)));

  p_lock_clears_arm_r6: assert property (@(posedge clk) disable iff (rst)
    (lock_q != $past(lock_q)) |-> !arm_q);

  p_lock_after_busy_r6: assert property (@(posedge clk) disable iff (rst)
    (lock_q != $past(lock_q)) |-> $past(busy_w));

  p_busy_from_cmd_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_w) |-> $past(cmd_en));

  p_cfg_only_recall_r10: assert property (@(posedge clk) disable iff (rst)
    !$past(cmd_en) |-> $stable({chg_en, dis_en, sleep_en}));
endmodule

// File: tb/nvblk_mgr_test.sv
`timescale 1ns/1ps
module nvblk_mgr_test;
  localparam int PROG = 40;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] addr = 8'h00, wdata = 8'h00;
  logic       wr_en = 1'b0, cmd_en = 1'b0;
  logic [7:0] rdata;
  logic       busy, chg_en, dis_en, sleep_en;

  int checks = 0, errors = 0, cyc = 0;
  logic rd_v = 1'b0, pend = 1'b0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  nvblk_mgr #(.PROG_CYC(PROG)) uut (
    .clk(clk), .rst(rst), .addr(addr), .wdata(wdata), .wr_en(wr_en),
    .cmd_en(cmd_en), .rdata(rdata), .busy(busy), .chg_en(chg_en),
    .dis_en(dis_en), .sleep_en(sleep_en)
  );

  always #10 clk = ~clk;

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic cmd(input logic [7:0] c);
    wdata = c; cmd_en = 1'b1;
    @(negedge clk); cmd_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [7:0] e, input string tag);
    addr = a; rd_v = 1'b1;
    exp_q.push_back(e); tag_q.push_back(tag);
    @(negedge clk); rd_v = 1'b0;
  endtask

  // monitor: pops expected read items one cycle after the address
  always @(posedge clk) pend <= rd_v;
  always @(negedge clk) begin
    if (pend && exp_q.size() > 0) chk(rdata, exp_q.pop_front(), tag_q.pop_front());
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R9: reset state, NV erased to FF
    chk({5'b0, chg_en, dis_en, sleep_en}, 8'h07, "R9 cfg after reset");
    chk({7'b0, busy}, 8'h00, "R9 busy after reset");
    rd(8'h07, 8'h00, "R9 status after reset");
    rd(8'h25, 8'hFF, "R9 shadow reloaded");
    // R1 / R11
    wr(8'h20, 8'h11); wr(8'h2F, 8'h22); wr(8'h47, 8'h33);
    rd(8'h20, 8'h11, "R1 block0 low");
    rd(8'h2F, 8'h22, "R1 block0 high");
    rd(8'h47, 8'h33, "R1 block2 last");
    rd(8'h48, 8'h00, "R11 past map");
    rd(8'h10, 8'h00, "R11 unmapped");
    // R2 copy block1 with R4/R5 traffic in the busy window
    wr(8'h30, 8'h02); wr(8'h31, 8'h00);
    cmd(8'h44);                                   // k=0
    chk({7'b0, busy}, 8'h01, "R2 busy raised");
    rd(8'h07, 8'h80, "R2 status busy bit");       // k=1
    wr(8'h35, 8'hAA);                             // k=2 target block
    wr(8'h21, 8'h55);                             // k=3 other block
    cmd(8'h42);                                   // k=4 dropped
    repeat (PROG - 5) @(negedge clk);             // k=PROG-1
    chk({7'b0, busy}, 8'h01, "R2 busy still high at last cycle");
    @(negedge clk);                               // k=PROG
    chk({7'b0, busy}, 8'h00, "R2 busy low after PROG_CYC");
    rd(8'h35, 8'hFF, "R4 target write ignored");
    rd(8'h21, 8'h55, "R4 other block write");
    // R10 recall block1 loads cfg
    cmd(8'hB4);
    chk({5'b0, chg_en, dis_en, sleep_en}, 8'h04, "R10 cfg after recall");
    rd(8'h30, 8'h02, "R2 NV holds copied byte");
    wr(8'h3F, 8'h77); cmd(8'hB4);
    rd(8'h3F, 8'hFF, "R3 recall restores shadow");
    // R5: block0 copy was dropped -> recall gives NV FF
    cmd(8'hB2);
    rd(8'h20, 8'hFF, "R5 busy copy dropped");
    cmd(8'h43);
    chk({7'b0, busy}, 8'h00, "R5 unknown code");
    // R6 lock
    cmd(8'h63);
    chk({7'b0, busy}, 8'h00, "R6 lock without arm");
    rd(8'h07, 8'h00, "R6 no lock flag");
    wr(8'h07, 8'h40);
    rd(8'h07, 8'h40, "R6 arm set");
    cmd(8'h6A);
    chk({7'b0, busy}, 8'h01, "R6 lock busy");
    repeat (PROG) @(negedge clk);
    rd(8'h07, 8'h04, "R6 flag set arm cleared");
    // R7 locked block
    wr(8'h40, 8'h99);
    rd(8'h40, 8'hFF, "R7 locked write ignored");
    cmd(8'h48);
    chk({7'b0, busy}, 8'h00, "R7 locked copy dropped");
    cmd(8'hB8);
    rd(8'h47, 8'hFF, "R3 recall on locked block");
    // R8 read-only flags
    wr(8'h07, 8'h00);
    rd(8'h07, 8'h04, "R8 flag not cleared");
    wr(8'h07, 8'hFF);
    rd(8'h07, 8'h44, "R8 only arm writable");
    // R9 second power-up
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    chk({5'b0, chg_en, dis_en, sleep_en}, 8'h04, "R9 cfg from copied NV");
    rd(8'h07, 8'h04, "R8 lock survives reset");
    rd(8'h30, 8'h02, "R9 shadow from NV");
    repeat (3) @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule